// File: doc/BRIEF.md
# Wakeup Pin and Regulator Controller

This block watches two external wakeup pins and decides the state of the core regulator while the chip is in deep sleep. Each pin is sampled on a slow low-power time base. A pin passes through a two-stage synchronizer and then a stability filter. A level change is accepted only after it has held for a set number of slow periods, three by default. If the pin is enabled when its change is accepted, the pin's sticky wakeup flag is set. Any set flag raises the wake request. Pin 0 can also raise an interrupt.

The slow time base comes in as a one-cycle enable strobe, `slowTick`, in the fast clock domain. The block therefore has a single clock.

Software writes the alternative-supply switch bit. A reset clears it. While the deep-sleep indication is high, the switch bit and the regulator-off bit select one of three supply states:

- The switch bit takes priority and forces the regulator off with the switch on.
- Otherwise the regulator-off bit chooses between low-current mode and off.

In run mode the regulator stays in normal mode and the switch stays off.

Top module: `wake_regulator_ctrl`

## Requirements
- R1: After reset `wakeFlag`=2'b00, `wakeReq`=0, `wakeIrq`=0, `swBitQ`=0, and `regLowCur`, `regOff` and `altSwOn` are all 0.
- R2: A pin whose enable bit (`pinEn[i]`) is 0 never sets `wakeFlag[i]`, whatever its level does. Its accepted level still follows the pin.
- R3: With `pinEn[i]`=1, a level change in either direction that holds for at least STABLE_TICKS (3) slow periods sets `wakeFlag[i]` (bit i belongs to pin i).
- R4: A level change that holds for fewer than STABLE_TICKS slow periods is ignored and sets no flag.
- R5: A wakeup flag stays 1 until its `clrFlag[i]` strobe is 1 for a cycle. It is then 0 in the next cycle. `wakeReq` is the OR of both flags.
- R6: `wakeIrq` is 1 exactly when `irqEn0`, `pinEn[0]` and `wakeFlag[0]` are all 1. It falls in the cycle after a clear strobe on pin 0.
- R7: When `deepSleep`=0, the registered outputs are `regLowCur`=0, `regOff`=0 and `altSwOn`=0 one cycle later.
- R8: When `deepSleep`=1 and the switch bit is 1, the outputs are `regOff`=1, `altSwOn`=1 and `regLowCur`=0 one cycle later, whatever `regOffBit` is.
- R9: When `deepSleep`=1 and the switch bit is 0, `altSwOn`=0 one cycle later. If `regOffBit` is 0, the outputs are `regLowCur`=1 and `regOff`=0. If `regOffBit` is 1, they are `regLowCur`=0 and `regOff`=1.
- R10: The switch bit takes `swWrData` on a cycle with `swWrEn`=1, holds otherwise, is visible on `swBitQ`, and is cleared by `rstN`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset of the main supply domain |
| slowTick | input | 1 | One-cycle strobe for each slow low-power period |
| pinIn | input | 2 | Raw wakeup pin levels |
| pinEn | input | 2 | Per-pin wakeup enable |
| irqEn0 | input | 1 | Interrupt enable for pin 0 |
| clrFlag | input | 2 | Write-one-to-clear strobes for the wakeup flags |
| swWrEn | input | 1 | Write strobe for the switch bit |
| swWrData | input | 1 | Value written to the switch bit |
| regOffBit | input | 1 | Deep-sleep regulator-off selection |
| deepSleep | input | 1 | Deep-sleep indication |
| wakeFlag | output | 2 | Sticky per-pin wakeup flags |
| wakeReq | output | 1 | Wake request, set when any flag is set |
| wakeIrq | output | 1 | Pin 0 wakeup interrupt |
| swBitQ | output | 1 | Current switch bit |
| regLowCur | output | 1 | Regulator in low-current mode |
| regOff | output | 1 | Regulator switched off |
| altSwOn | output | 1 | Alternative supply switch on |

## Verification
The assertions assume that `slowTick` is a single-cycle strobe and that pins are sampled only on that strobe. They also assume that software clear strobes last one cycle. The bench generates `slowTick` every fourth clock and changes each pin on a falling clock edge. It holds each pin for a whole number of slow periods, so a pulse of K periods is sampled exactly K times. The bench issues clear strobes only after a pin's filter has settled, so no flag is set and cleared in the same cycle.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
  localparam int NUM_PINS = 2;

  typedef struct packed {
    logic [NUM_PINS-1:0] setFlag;
    logic [NUM_PINS-1:0] clrFlag;
    logic                swWr;
    logic                swVal;
  } wkpStrobes_t;
endpackage

// File: rtl/wkp_pin_filter.sv
module wkp_pin_filter #(
  parameter int STABLE_TICKS = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic slowTick,
  input  logic pinIn,
  output logic acceptQ
);
  localparam int CNT_W = $clog2(STABLE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_TICKS - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncLvl;
  logic                   accLvl;
  logic [CNT_W-1:0]       stableCnt;

  assign syncLvl = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      accLvl    <= 1'b0;
      stableCnt <= '0;
      acceptQ   <= 1'b0;
    end else begin
      acceptQ <= 1'b0;
      if (slowTick) begin
        syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn};
        if (syncLvl == accLvl) begin
          stableCnt <= '0;
        end else if (stableCnt == LAST) begin
          accLvl    <= syncLvl;
          stableCnt <= '0;
          acceptQ   <= 1'b1;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end
    end
  end

  // R3 R4
  accept_on_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    acceptQ |-> ($past(slowTick) && ($past(syncLvl) == accLvl) && ($past(accLvl) != accLvl)));
endmodule

// File: rtl/wkp_ctrl.sv
module wkp_ctrl
  import wkp_pkg::*;
#(
  parameter int STABLE_TICKS = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                slowTick,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinEn,
  input  logic [NUM_PINS-1:0] clrFlag,
  input  logic                swWrEn,
  input  logic                swWrData,
  output wkpStrobes_t         strobes
);
  logic [NUM_PINS-1:0] accept;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    wkp_pin_filter #(
      .STABLE_TICKS(STABLE_TICKS),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_filter (
      .clk     (clk),
      .rstN    (rstN),
      .slowTick(slowTick),
      .pinIn   (pinIn[i]),
      .acceptQ (accept[i])
    );
  end

  always_comb begin
    strobes.setFlag = accept & pinEn;
    strobes.clrFlag = clrFlag;
    strobes.swWr    = swWrEn;
    strobes.swVal   = swWrData;
  end
endmodule

// File: rtl/wkp_data.sv
module wkp_data
  import wkp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  wkpStrobes_t         strobes,
  input  logic                pinEn0,
  input  logic                irqEn0,
  input  logic                regOffBit,
  input  logic                deepSleep,
  output logic [NUM_PINS-1:0] wakeFlag,
  output logic                wakeReq,
  output logic                wakeIrq,
  output logic                swBitQ,
  output logic                regLowCur,
  output logic                regOff,
  output logic                altSwOn
);
  logic [NUM_PINS-1:0] flagQ;
  logic                swBit;
  logic                nxtLowCur, nxtOff, nxtAlt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      swBit <= 1'b0;
    end else begin
      flagQ <= (flagQ & ~strobes.clrFlag) | strobes.setFlag;
      if (strobes.swWr) swBit <= strobes.swVal;
    end
  end

  always_comb begin
    nxtLowCur = 1'b0;
    nxtOff    = 1'b0;
    nxtAlt    = 1'b0;
    if (deepSleep) begin
      if (swBit) begin
        nxtOff = 1'b1;
        nxtAlt = 1'b1;
      end else if (regOffBit) begin
        nxtOff = 1'b1;
      end else begin
        nxtLowCur = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regLowCur <= 1'b0;
      regOff    <= 1'b0;
      altSwOn   <= 1'b0;
    end else begin
      regLowCur <= nxtLowCur;
      regOff    <= nxtOff;
      altSwOn   <= nxtAlt;
    end
  end

  assign wakeFlag = flagQ;
  assign wakeReq  = |flagQ;
  assign wakeIrq  = irqEn0 & pinEn0 & flagQ[0];
  assign swBitQ   = swBit;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[i] && !strobes.clrFlag[i]) |=> flagQ[i]);
    // R2 R3
    flag_needs_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagQ[i]) |-> $past(strobes.setFlag[i]));
  end

  // R6
  irq_falls_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrFlag[0] && !strobes.setFlag[0]) |=> !wakeIrq);
  // R7
  run_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    !deepSleep |=> (!regLowCur && !regOff && !altSwOn));
  // R8
  switch_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deepSleep && swBit) |=> (regOff && altSwOn && !regLowCur));
  // R9
  ldo_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deepSleep && !swBit) |=> (!altSwOn && (regOff != regLowCur)));
  // R10
  switch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.swWr |=> $stable(swBitQ));
endmodule

// File: rtl/wake_regulator_ctrl.sv
module wake_regulator_ctrl
  import wkp_pkg::*;
#(
  parameter int STABLE_TICKS = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slowTick,
  input  logic [1:0] pinIn,
  input  logic [1:0] pinEn,
  input  logic       irqEn0,
  input  logic [1:0] clrFlag,
  input  logic       swWrEn,
  input  logic       swWrData,
  input  logic       regOffBit,
  input  logic       deepSleep,
  output logic [1:0] wakeFlag,
  output logic       wakeReq,
  output logic       wakeIrq,
  output logic       swBitQ,
  output logic       regLowCur,
  output logic       regOff,
  output logic       altSwOn
);
  wkpStrobes_t strobes;

  wkp_ctrl #(
    .STABLE_TICKS(STABLE_TICKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .slowTick(slowTick),
    .pinIn   (pinIn),
    .pinEn   (pinEn),
    .clrFlag (clrFlag),
    .swWrEn  (swWrEn),
    .swWrData(swWrData),
    .strobes (strobes)
  );

  wkp_data u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .pinEn0   (pinEn[0]),
    .irqEn0   (irqEn0),
    .regOffBit(regOffBit),
    .deepSleep(deepSleep),
    .wakeFlag (wakeFlag),
    .wakeReq  (wakeReq),
    .wakeIrq  (wakeIrq),
    .swBitQ   (swBitQ),
    .regLowCur(regLowCur),
    .regOff   (regOff),
    .altSwOn  (altSwOn)
  );
endmodule

// File: tb/wake_regulator_ctrl_tb.sv
`timescale 1ns/1ps
module wake_regulator_ctrl_tb;
  localparam int TDIV   = 4;
  localparam int SETTLE = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       slowTick = 1'b0;
  logic [1:0] pinIn = '0, pinEn = '0, clrFlag = '0;
  logic       irqEn0 = 0, swWrEn = 0, swWrData = 0, regOffBit = 0, deepSleep = 0;
  logic [1:0] wakeFlag;
  logic       wakeReq, wakeIrq, swBitQ, regLowCur, regOff, altSwOn;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wake_regulator_ctrl u_dut (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .pinIn(pinIn), .pinEn(pinEn),
    .irqEn0(irqEn0), .clrFlag(clrFlag), .swWrEn(swWrEn), .swWrData(swWrData),
    .regOffBit(regOffBit), .deepSleep(deepSleep), .wakeFlag(wakeFlag),
    .wakeReq(wakeReq), .wakeIrq(wakeIrq), .swBitQ(swBitQ), .regLowCur(regLowCur),
    .regOff(regOff), .altSwOn(altSwOn)
  );

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt = (cnt + 1) % TDIV;
      slowTick = (cnt == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearAll();
    clrFlag = 2'b11;
    cyc(1);
    clrFlag = 2'b00;
    cyc(1);
  endtask

  task automatic pulse(input int p, input int k);
    pinIn[p] = 1'b1;
    cyc(k * TDIV);
    pinIn[p] = 1'b0;
    cyc(SETTLE);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    // R1 reset state
    chk("R1 flags", wakeFlag, 0);
    chk("R1 req", wakeReq, 0);
    chk("R1 irq", wakeIrq, 0);
    chk("R1 sw", swBitQ, 0);
    chk("R1 reg", {regLowCur, regOff, altSwOn}, 0);

    // R2 R3 R4 sweep: pin, enable, pulse width
    for (int p = 0; p < 2; p++)
      for (int en = 0; en < 2; en++)
        for (int k = 2; k <= 4; k++) begin
          int expF;
          pinEn = 2'(en << p);
          pulse(p, k);
          expF = (en == 1 && k >= 3) ? 1 : 0;
          if (en == 0) chk("R2 disabled pin flag", wakeFlag[p], 0);
          else if (k < 3) chk("R4 short pulse flag", wakeFlag[p], 0);
          else chk("R3 qualified pulse flag", wakeFlag[p], 1);
          chk("R5 req is OR", wakeReq, expF);
          chk("R2 other pin untouched", wakeFlag[1-p], 0);
          clearAll();
          chk("R5 cleared", wakeFlag, 0);
        end

    // R3 falling change on pin 1
    pinEn = 2'b00;
    pinIn[1] = 1'b1;
    cyc(SETTLE);
    chk("R2 disabled rise", wakeFlag[1], 0);
    pinEn = 2'b10;
    pinIn[1] = 1'b0;
    cyc(2 * TDIV);
    pinIn[1] = 1'b1;
    cyc(SETTLE);
    chk("R4 short low pulse", wakeFlag[1], 0);
    pinIn[1] = 1'b0;
    cyc(SETTLE);
    chk("R3 falling change", wakeFlag[1], 1);
    clearAll();

    // R6 interrupt gating
    pinEn = 2'b01;
    pulse(0, 3);
    irqEn0 = 1'b1;
    cyc(1);
    chk("R6 irq all set", wakeIrq, 1);
    irqEn0 = 1'b0;
    cyc(1);
    chk("R6 irq enable off", wakeIrq, 0);
    irqEn0 = 1'b1;
    pinEn = 2'b00;
    cyc(1);
    chk("R6 pin enable off", wakeIrq, 0);
    pinEn = 2'b01;
    cyc(100);
    chk("R5 sticky", wakeFlag[0], 1);
    chk("R6 irq back", wakeIrq, 1);
    clrFlag = 2'b01;
    cyc(1);
    clrFlag = 2'b00;
    chk("R6 irq falls after clear", wakeIrq, 0);
    chk("R5 flag cleared", wakeFlag[0], 0);
    irqEn0 = 1'b0;

    // R7 R8 R9 R10 regulator sweep
    for (int ds = 0; ds < 2; ds++)
      for (int sw = 0; sw < 2; sw++)
        for (int ro = 0; ro < 2; ro++) begin
          int eLow, eOff, eAlt;
          swWrEn = 1'b1;
          swWrData = sw[0];
          cyc(1);
          swWrEn = 1'b0;
          swWrData = ~sw[0];
          deepSleep = ds[0];
          regOffBit = ro[0];
          cyc(2);
          chk("R10 switch bit", swBitQ, sw);
          eAlt = ds * sw;
          eOff = ds * ((sw | ro) != 0 ? 1 : 0);
          eLow = ds * (1 - sw) * (1 - ro);
          if (ds == 0) chk("R7 run mode", {regLowCur, regOff, altSwOn}, 0);
          else if (sw == 1) chk("R8 switch priority", {regLowCur, regOff, altSwOn}, 4 * eLow + 2 * eOff + eAlt);
          else chk("R9 regulator bit", {regLowCur, regOff, altSwOn}, 4 * eLow + 2 * eOff + eAlt);
        end

    // R10 reset clears switch bit
    swWrEn = 1'b1;
    swWrData = 1'b1;
    cyc(1);
    swWrEn = 1'b0;
    cyc(1);
    chk("R10 written", swBitQ, 1);
    rstN = 1'b0;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
    chk("R10 reset clears", swBitQ, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule